// File: doc/BRIEF.md
# Stuffed Single-Wire Frame Transmitter

This block takes a payload of bytes from a byte-stream handshake, where the first and last bytes are marked. It returns that payload as a serial bit stream. The stream has a start flag, the payload, a 16-bit CRC, and an end flag, in that order. Every byte is sent least significant bit first. The bits leave through a bit-level ready/valid pair, which a downstream duty-cycle line coder drains at its own pace.

The whole payload is buffered before the first bit goes out. A payload that is too long, empty or interrupted can therefore be dropped without putting anything on the line. Inside the payload and CRC region, a 0 bit is inserted after every five consecutive ones. Because of this, neither flag pattern can appear inside the body of a frame.

Top module: `sw_frame_tx`

## Requirements
- R1: After reset, `in_ready_o` is 1, and `bit_valid_o`, `done_o`, `len_err_o` and `underrun_o` are 0.
- R2: A frame goes out in this order: start flag 0x7E, payload bytes in arrival order, CRC, end flag 0x7F. Each byte is serialised bit 0 first.
- R3: In the payload and CRC region, a 0 bit is inserted after every five consecutive 1 bits. The run count starts at zero at the first payload bit and restarts after each inserted bit. The flags are never stuffed, so the start flag shows six ones and the end flag seven.
- R4: The CRC uses polynomial x^16+x^12+x^5+1, processed bit-reflected (LSB first), with start value 0xFFFF. The final value is inverted and sent low byte first.
- R5: Payloads of 1 to 30 bytes are sent. When a 31st byte arrives without the last marker, `len_err_o` pulses for one cycle. The frame is then discarded up to and including its last-marked byte, and no bit is sent.
- R6: While no frame is open, a beat with the last marker and no first marker counts as an empty payload. It pulses `len_err_o` and nothing is sent. A beat with neither marker is dropped.
- R7: A frame is open once its first byte has been taken. If `in_valid_o` is low in any cycle before the last byte of an open frame, `underrun_o` pulses for one cycle. The frame is then discarded, nothing is sent, and the next first-marked byte starts a new frame.
- R8: While `bit_valid_o` is 1 and `bit_ready_i` is 0, `bit_valid_o` and `bit_o` hold their values into the next cycle.
- R9: `done_o` pulses for exactly one cycle, in the cycle right after the last end-flag bit is accepted.
- R10: `in_ready_o` is 0 from the cycle after a valid frame's last byte is taken until the frame is done. It is never 1 while `bit_valid_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | 8 | Payload byte |
| in_valid_i | input | 1 | Payload byte valid |
| in_first_i | input | 1 | Byte is the first of a payload |
| in_last_i | input | 1 | Byte is the last of a payload |
| in_ready_o | output | 1 | Block accepts a payload byte |
| bit_o | output | 1 | Serial output bit |
| bit_valid_o | output | 1 | Serial bit valid |
| bit_ready_i | input | 1 | Downstream takes the serial bit |
| done_o | output | 1 | Frame fully sent (one-cycle pulse) |
| len_err_o | output | 1 | Empty or oversized payload dropped (pulse) |
| underrun_o | output | 1 | Payload stalled mid-frame, dropped (pulse) |

## Verification
Four payload patterns are used, each checked bit for bit against a frame model built in the bench:
- A single zero byte checks flag placement and the CRC with no stuffing at all.
- A run of 0xFF bytes forces a stuffed bit every five ones, showing whether the run count restarts correctly.
- A 30-byte mixed pattern under random back-pressure exposes any bit that is dropped or repeated while the output is stalled.
- A single 0xFF byte under stalls checks the short stuffed case.

Oversized, empty and stalled payloads are sent to show that each one raises its own flag and leaves the line silent. A clean frame afterwards shows that the block has recovered.

// File: rtl/sw_frame_tx_pkg.sv
package sw_frame_tx_pkg;

  localparam logic [7:0]  SOF_BYTE  = 8'h7E;
  localparam logic [7:0]  EOF_BYTE  = 8'h7F;
  localparam logic [15:0] CRC_INIT  = 16'hFFFF;
  localparam logic [15:0] CRC_RPOLY = 16'h8408;  // x^16+x^12+x^5+1, reflected

  typedef enum logic [1:0] {C_IDLE, C_FILL, C_DRAIN, C_HOLD} col_state_e;
  typedef enum logic [1:0] {T_IDLE, T_SOF, T_BODY, T_EOF} tx_state_e;

  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_RPOLY;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/sw_frame_collect.sv
module sw_frame_collect
  import sw_frame_tx_pkg::*;
#(
  parameter int MAX_LEN = 30,
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int IDX_W  = $clog2(MAX_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       data_i,
  input  logic             valid_i,
  input  logic             first_i,
  input  logic             last_i,
  output logic             ready_o,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [7:0]       rd_byte_o,
  output logic [LEN_W-1:0] len_o,
  output logic [15:0]      crc_o,
  output logic             frame_rdy_o,
  input  logic             tx_done_i,
  output logic             len_err_o,
  output logic             underrun_o
);

  col_state_e       st_q;
  logic [LEN_W-1:0] cnt_q;
  logic [15:0]      crc_q;
  logic             len_err_q, underrun_q;
  logic [7:0]       mem_q [MAX_LEN];
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic             full;

  assign ready_o     = (st_q != C_HOLD);
  assign frame_rdy_o = (st_q == C_HOLD);
  assign len_o       = cnt_q;
  assign crc_o       = crc_q;
  assign len_err_o   = len_err_q;
  assign underrun_o  = underrun_q;
  assign full        = (cnt_q == LEN_W'(MAX_LEN));

  assign wr_en  = valid_i & ((st_q == C_IDLE & first_i) | (st_q == C_FILL & ~full));
  assign wr_idx = (st_q == C_IDLE) ? '0 : cnt_q[IDX_W-1:0];

  assign rd_byte_o = (int'(rd_idx_i) < MAX_LEN) ? mem_q[rd_idx_i] : 8'h00;

  always_ff @(posedge clk_i) begin
    if (wr_en) mem_q[wr_idx] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= C_IDLE;
      cnt_q      <= '0;
      crc_q      <= CRC_INIT;
      len_err_q  <= 1'b0;
      underrun_q <= 1'b0;
    end else begin
      len_err_q  <= 1'b0;
      underrun_q <= 1'b0;
      case (st_q)
        C_IDLE: begin
          if (valid_i) begin
            if (first_i) begin
              cnt_q <= LEN_W'(1);
              crc_q <= crc_byte(CRC_INIT, data_i);
              st_q  <= last_i ? C_HOLD : C_FILL;
            end else if (last_i) begin
              len_err_q <= 1'b1;  // empty payload
            end
          end
        end
        C_FILL: begin
          if (!valid_i) begin
            underrun_q <= 1'b1;
            st_q       <= C_IDLE;
          end else if (full) begin
            len_err_q <= 1'b1;
            st_q      <= last_i ? C_IDLE : C_DRAIN;
          end else begin
            cnt_q <= cnt_q + LEN_W'(1);
            crc_q <= crc_byte(crc_q, data_i);
            if (last_i) st_q <= C_HOLD;
          end
        end
        C_DRAIN: begin
          if (valid_i && last_i) st_q <= C_IDLE;
        end
        C_HOLD: begin
          if (tx_done_i) st_q <= C_IDLE;
        end
        default: st_q <= C_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sw_bit_stuffer.sv
module sw_bit_stuffer #(
  parameter int RUN_LEN = 5,
  localparam int CNT_W  = $clog2(RUN_LEN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic adv_i,
  input  logic bit_i,
  output logic stuff_o,
  output logic will_stuff_o
);

  logic [CNT_W-1:0] ones_q;

  assign stuff_o      = (ones_q == CNT_W'(RUN_LEN));
  assign will_stuff_o = bit_i & (ones_q == CNT_W'(RUN_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ones_q <= '0;
    else if (clear_i)  ones_q <= '0;
    else if (adv_i) begin
      if (stuff_o)     ones_q <= '0;
      else if (bit_i)  ones_q <= ones_q + CNT_W'(1);
      else             ones_q <= '0;
    end
  end

endmodule

// File: rtl/sw_frame_tx.sv
module sw_frame_tx
  import sw_frame_tx_pkg::*;
#(
  parameter int MAX_LEN = 30,
  parameter int RUN_LEN = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] in_data_i,
  input  logic       in_valid_i,
  input  logic       in_first_i,
  input  logic       in_last_i,
  output logic       in_ready_o,
  output logic       bit_o,
  output logic       bit_valid_o,
  input  logic       bit_ready_i,
  output logic       done_o,
  output logic       len_err_o,
  output logic       underrun_o
);

  localparam int LEN_W = $clog2(MAX_LEN + 1);
  localparam int IDX_W = $clog2(MAX_LEN);
  localparam int POS_W = $clog2(8 * MAX_LEN + 17);

  logic [IDX_W-1:0] rd_idx;
  logic [7:0]       rd_byte;
  logic [LEN_W-1:0] len;
  logic [15:0]      crc;
  logic             frame_rdy, tx_done;

  tx_state_e        st_q;
  logic [2:0]       fcnt_q;
  logic [POS_W-1:0] pos_q, pay_bits, total, crc_off;
  logic             raw_bit, stuff, will_stuff, acc, last_data, done_q;

  sw_frame_collect #(.MAX_LEN(MAX_LEN)) u_collect (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .data_i      (in_data_i),
    .valid_i     (in_valid_i),
    .first_i     (in_first_i),
    .last_i      (in_last_i),
    .ready_o     (in_ready_o),
    .rd_idx_i    (rd_idx),
    .rd_byte_o   (rd_byte),
    .len_o       (len),
    .crc_o       (crc),
    .frame_rdy_o (frame_rdy),
    .tx_done_i   (tx_done),
    .len_err_o   (len_err_o),
    .underrun_o  (underrun_o)
  );

  assign pay_bits  = POS_W'(len) << 3;
  assign total     = pay_bits + POS_W'(16);
  assign crc_off   = pos_q - pay_bits;
  assign rd_idx    = IDX_W'(pos_q >> 3);
  assign raw_bit   = (pos_q < pay_bits) ? rd_byte[pos_q[2:0]] : ~crc[crc_off[3:0]];
  assign last_data = (pos_q + POS_W'(1) == total);

  sw_bit_stuffer #(.RUN_LEN(RUN_LEN)) u_stuff (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (st_q != T_BODY),
    .adv_i        (acc & (st_q == T_BODY)),
    .bit_i        (raw_bit),
    .stuff_o      (stuff),
    .will_stuff_o (will_stuff)
  );

  always_comb begin
    bit_valid_o = (st_q != T_IDLE);
    case (st_q)
      T_SOF:   bit_o = SOF_BYTE[fcnt_q];
      T_EOF:   bit_o = EOF_BYTE[fcnt_q];
      T_BODY:  bit_o = stuff ? 1'b0 : raw_bit;
      default: bit_o = 1'b0;
    endcase
  end

  assign acc     = bit_valid_o & bit_ready_i;
  assign tx_done = (st_q == T_EOF) & acc & (fcnt_q == 3'd7);
  assign done_o  = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= T_IDLE;
      fcnt_q <= '0;
      pos_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= tx_done;
      case (st_q)
        T_IDLE: begin
          if (frame_rdy) begin
            st_q   <= T_SOF;
            fcnt_q <= '0;
          end
        end
        T_SOF: begin
          if (acc) begin
            fcnt_q <= fcnt_q + 3'd1;
            if (fcnt_q == 3'd7) begin
              st_q  <= T_BODY;
              pos_q <= '0;
            end
          end
        end
        T_BODY: begin
          if (acc) begin
            if (stuff) begin
              if (pos_q == total) st_q <= T_EOF;
            end else begin
              pos_q <= pos_q + POS_W'(1);
              if (last_data && !will_stuff) st_q <= T_EOF;
            end
          end
        end
        T_EOF: begin
          if (acc) begin
            fcnt_q <= fcnt_q + 3'd1;
            if (fcnt_q == 3'd7) st_q <= T_IDLE;
          end
        end
        default: st_q <= T_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sw_frame_tx_chk.sv
module sw_frame_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic in_valid_i,
  input logic in_ready_o,
  input logic bit_o,
  input logic bit_valid_o,
  input logic bit_ready_i,
  input logic done_o,
  input logic len_err_o,
  input logic underrun_o
);

  // R8
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o && !bit_ready_i |=> bit_valid_o && $stable(bit_o));

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !bit_valid_o);

  // R10
  no_take_while_tx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |-> !in_ready_o);

  // R5
  len_err_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_err_o |=> !bit_valid_o);

  // R7
  underrun_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |=> !bit_valid_o && in_ready_o);

  // R1
  events_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, len_err_o, underrun_o}));

endmodule

bind sw_frame_tx sw_frame_tx_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .bit_o       (bit_o),
  .bit_valid_o (bit_valid_o),
  .bit_ready_i (bit_ready_i),
  .done_o      (done_o),
  .len_err_o   (len_err_o),
  .underrun_o  (underrun_o)
);

// File: tb/tb_sw_frame_tx.sv
`timescale 1ns/1ps
module tb_sw_frame_tx;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] in_data_i = '0;
  logic       in_valid_i = 1'b0, in_first_i = 1'b0, in_last_i = 1'b0;
  logic       in_ready_o, bit_o, bit_valid_o;
  logic       bit_ready_i = 1'b1;
  logic       done_o, len_err_o, underrun_o;

  always #10 clk = ~clk;  // 50 MHz

  sw_frame_tx dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_data_i(in_data_i), .in_valid_i(in_valid_i),
    .in_first_i(in_first_i), .in_last_i(in_last_i), .in_ready_o(in_ready_o),
    .bit_o(bit_o), .bit_valid_o(bit_valid_o), .bit_ready_i(bit_ready_i),
    .done_o(done_o), .len_err_o(len_err_o), .underrun_o(underrun_o)
  );

  int tests = 0, fails = 0;
  logic got_q[$];
  logic exp_q[$];
  logic [7:0] pl [0:31];
  int done_cnt = 0, lerr_cnt = 0, urun_cnt = 0;
  int smp = 0, last_acc_smp = 0, done_smp = 0;
  int stall_bad = 0, overlap_bad = 0;
  bit bp_mode = 0;
  logic [7:0] lfsr = 8'hA5;
  logic prev_stall = 0, prev_bit = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // back-pressure driver and output monitor
  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    bit_ready_i <= bp_mode ? lfsr[0] : 1'b1;
    #5;
    smp++;
    if (prev_stall && !(bit_valid_o && bit_o == prev_bit)) stall_bad++;
    prev_stall = bit_valid_o && !bit_ready_i;
    prev_bit   = bit_o;
    if (bit_valid_o && in_ready_o) overlap_bad++;
    if (bit_valid_o && bit_ready_i) begin
      got_q.push_back(bit_o);
      last_acc_smp = smp;
    end
    if (done_o) begin done_cnt++; done_smp = smp; end
    if (len_err_o) lerr_cnt++;
    if (underrun_o) urun_cnt++;
  end

  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) begin
        logic fb = c[0] ^ pl[i][b];
        c = c >> 1;
        if (fb) c = c ^ 16'h8408;
      end
    return ~c;
  endfunction

  task automatic build_exp(input int n);
    logic [15:0] c = ref_crc(n);
    int ones = 0;
    exp_q.delete();
    for (int b = 0; b < 8; b++) exp_q.push_back(1'(8'h7E >> b));
    for (int i = 0; i < n + 2; i++) begin
      logic [7:0] v = (i < n) ? pl[i] : ((i == n) ? c[7:0] : c[15:8]);
      for (int b = 0; b < 8; b++) begin
        exp_q.push_back(v[b]);
        ones = v[b] ? ones + 1 : 0;
        if (ones == 5) begin exp_q.push_back(1'b0); ones = 0; end
      end
    end
    for (int b = 0; b < 8; b++) exp_q.push_back(1'(8'h7F >> b));
  endtask

  task automatic clear_mon();
    @(negedge clk);
    #6;
    got_q.delete();
    done_cnt = 0; lerr_cnt = 0; urun_cnt = 0;
    stall_bad = 0; overlap_bad = 0;
  endtask

  task automatic put_bytes(input int n, input bit mark_last);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid_i = 1'b1;
      in_data_i  = pl[i];
      in_first_i = (i == 0);
      in_last_i  = mark_last && (i == n - 1);
    end
    @(negedge clk);
    in_valid_i = 1'b0; in_first_i = 1'b0; in_last_i = 1'b0;
  endtask

  task automatic wait_quiet(input int cyc);
    repeat (cyc) @(negedge clk);
    #6;
  endtask

  task automatic run_frame(input string name, input int n, input bit bp);
    int bad = 0, first_bad = -1, run = 0, maxrun = 0;
    bp_mode = bp;
    clear_mon();
    build_exp(n);
    put_bytes(n, 1'b1);
    #5;
    chk(in_ready_o == 1'b0, "R10", {name, " in_ready after last byte"}, in_ready_o, 0);
    for (int k = 0; k < 4000 && done_cnt == 0; k++) @(negedge clk);
    wait_quiet(4);
    chk(got_q.size() == exp_q.size(), "R2", {name, " bit count"}, got_q.size(), exp_q.size());
    for (int k = 0; k < got_q.size() && k < exp_q.size(); k++)
      if (got_q[k] !== exp_q[k]) begin bad++; if (first_bad < 0) first_bad = k; end
    chk(bad == 0, "R2/R4", {name, " first mismatching bit index"}, first_bad, -1);
    for (int k = 8; k < got_q.size() - 8; k++) begin
      run = got_q[k] ? run + 1 : 0;
      if (run > maxrun) maxrun = run;
    end
    chk(maxrun <= 5, "R3", {name, " longest body run of ones"}, maxrun, 5);
    chk(done_cnt == 1, "R9", {name, " done pulses"}, done_cnt, 1);
    chk(done_smp == last_acc_smp + 1, "R9", {name, " done timing"}, done_smp, last_acc_smp + 1);
    chk(stall_bad == 0, "R8", {name, " stall violations"}, stall_bad, 0);
    chk(overlap_bad == 0, "R10", {name, " ready during send"}, overlap_bad, 0);
    chk(in_ready_o == 1'b1, "R10", {name, " ready after done"}, in_ready_o, 1);
    bp_mode = 0;
  endtask

  task automatic t_reset();
    #5;
    chk(in_ready_o == 1 && bit_valid_o == 0 && done_o == 0 && len_err_o == 0 && underrun_o == 0,
        "R1", "reset outputs", {in_ready_o, bit_valid_o, done_o, len_err_o, underrun_o}, 5'b10000);
  endtask

  task automatic t_zero_byte();
    pl[0] = 8'h00;
    run_frame("zero byte", 1, 0);
  endtask

  task automatic t_ones_run();
    pl[0] = 8'hFF; pl[1] = 8'hFF; pl[2] = 8'hFF; pl[3] = 8'hF8;
    run_frame("ones run", 4, 0);
  endtask

  task automatic t_max_len_bp();
    for (int i = 0; i < 30; i++) pl[i] = 8'(i * 37 + 5);
    run_frame("30 bytes bp", 30, 1);
  endtask

  task automatic t_single_ff_bp();
    pl[0] = 8'hFF;
    run_frame("one FF bp", 1, 1);
  endtask

  task automatic t_oversize();
    clear_mon();
    for (int i = 0; i < 32; i++) pl[i] = 8'(i);
    put_bytes(32, 1'b1);
    wait_quiet(40);
    chk(lerr_cnt == 1, "R5", "oversize len_err pulses", lerr_cnt, 1);
    chk(got_q.size() == 0, "R5", "oversize bits sent", got_q.size(), 0);
    chk(in_ready_o == 1, "R5", "oversize ready after drop", in_ready_o, 1);
  endtask

  task automatic t_empty();
    clear_mon();
    @(negedge clk);
    in_valid_i = 1; in_first_i = 0; in_last_i = 1; in_data_i = 8'h55;
    @(negedge clk);
    in_valid_i = 0; in_last_i = 0;
    wait_quiet(30);
    chk(lerr_cnt == 1, "R6", "empty len_err pulses", lerr_cnt, 1);
    chk(got_q.size() == 0, "R6", "empty bits sent", got_q.size(), 0);
    clear_mon();
    @(negedge clk);
    in_valid_i = 1; in_data_i = 8'h12;
    @(negedge clk);
    in_valid_i = 0;
    wait_quiet(20);
    chk(lerr_cnt == 0 && got_q.size() == 0, "R6", "unmarked beat effect", lerr_cnt + got_q.size(), 0);
  endtask

  task automatic t_underrun();
    clear_mon();
    pl[0] = 8'hAA; pl[1] = 8'hBB; pl[2] = 8'hCC;
    put_bytes(3, 1'b0);
    wait_quiet(40);
    chk(urun_cnt == 1, "R7", "underrun pulses", urun_cnt, 1);
    chk(got_q.size() == 0, "R7", "underrun bits sent", got_q.size(), 0);
    chk(lerr_cnt == 0, "R7", "underrun no len_err", lerr_cnt, 0);
    pl[0] = 8'h3C; pl[1] = 8'hC3;
    run_frame("after underrun", 2, 0);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #35;
    t_reset();
    rst_ni = 1'b1;
    wait_quiet(2);
    t_zero_byte();
    t_ones_run();
    t_max_len_bp();
    t_single_ff_bp();
    t_oversize();
    t_empty();
    t_underrun();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule